// File: doc/BRIEF.md
# Post-Transmit SQE Test Monitor

This block sits beside a 10 Mb/s MAC that drives an attachment-unit interface. When a frame ends, the external transceiver is expected to send back a short 10 MHz burst on the collision pair. This burst is the signal-quality-error test. The monitor runs on a 20 MHz sampling clock, where one bit time is two clocks. It times the gap from the end of transmission to the start of the burst, and it measures how long the burst lasts. If the burst is missing, arrives too early or is too short, the monitor raises a one-cycle error pulse.

While the burst is expected, the monitor also blanks receive carrier sense. This stops the test burst from being taken as the start of a received frame. The check runs only when the attachment-unit port is selected. A new transmission cancels a check that is in progress, and no error is reported in that case.

All signals are plain level controls. The block has no data stream and no back-pressure. Edge counts below are clock edges counted from edge 0, which is the first rising edge that samples `tx_active` low after it was high.

Top module: `sqe_test_monitor`

## Requirements
- R1: After reset, `mask_active` and `sqe_err` are 0, and `carrier_out` follows `carrier_in`.
- R2: When `tx_active` falls with `aui_sel`=1, `mask_active` rises after edge 0. While `mask_active` is 1, `carrier_out` is 0. Otherwise `carrier_out` equals `carrier_in`.
- R3: Suppose `col_active` is first seen high at edge s, with 12 ≤ s ≤ 32, and stays high for L edges, with 10 ≤ L ≤ 30. Then no error is raised, and masking drops after edge s+L, the first edge that sees it low.
- R4: If `col_active` is not seen high at any edge from 1 to 32, `sqe_err` is high for the cycle after edge 32. Masking stays on until after edge 62. Activity after edge 32 is ignored.
- R5: If `col_active` is first seen high at an edge s < 12, `sqe_err` is high for the cycle after edge s. Masking stays on until after edge 62.
- R6: If a burst that starts inside the window lasts L < 10 edges, `sqe_err` is high for the cycle after edge s+L, and masking drops at the same time.
- R7: If a burst that starts inside the window is still high at its 31st edge (edge s+30), masking drops after that edge and no error is raised.
- R8: If `tx_active` is seen high at any edge while masking, masking drops after that edge and no error is raised from that edge onward.
- R9: When `aui_sel`=0 at the end of transmission, neither masking nor an error occurs.
- R10: `sqe_err` is never high for two cycles in a row. It is high only in the cycle after an edge at which masking was active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 20 MHz sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_active | input | 1 | High while the MAC transmits |
| aui_sel | input | 1 | 1 = attachment-unit port selected, 0 = twisted-pair |
| carrier_in | input | 1 | Raw receive carrier sense |
| col_active | input | 1 | Collision-pair activity indication |
| carrier_out | output | 1 | Receive carrier sense after blanking |
| mask_active | output | 1 | High while carrier is blanked for the test |
| sqe_err | output | 1 | One-cycle pulse when the test burst is missing or bad |

## Verification
The bench places the start of the burst on both sides of each window limit: edges 11, 12, 32 and 33, plus no burst at all. This tells early activity, a valid start and a missed window apart. It varies the burst length around 9/10 and 30/31 edges, which separates a short burst, a good burst and a capped one. It raises `tx_active` in the middle of the check to show that an abort suppresses a pending error. It repeats ends of transmission with the twisted-pair port selected to show the check is inactive there. Random cases mix all of these, and random carrier input is applied every cycle to check the blanking.

// File: rtl/sqe_mon_pkg.sv
package sqe_mon_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_BURST = 2'd2,
    ST_HOLD  = 2'd3
  } sqe_state_e;
endpackage

// File: rtl/sqe_tx_edge.sv
// Detects the end of a transmission on the attachment-unit port.
module sqe_tx_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_active,
  input  logic aui_sel,
  output logic end_pulse
);
  logic tx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) tx_q <= 1'b0;
    else        tx_q <= tx_active;
  end

  assign end_pulse = tx_q & ~tx_active & aui_sel;
endmodule

// File: rtl/sqe_win_timer.sv
// Counts edges since the end of transmission and flags the window limits.
module sqe_win_timer #(
  parameter int unsigned EARLY_MIN  = 12,
  parameter int unsigned WIN_CLOSE  = 32,
  parameter int unsigned RELEASE_AT = 62,
  parameter int unsigned CNT_W      = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic too_early,
  output logic at_close,
  output logic at_release
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                      cnt <= '0;
    else if (load)                   cnt <= CNT_W'(1);
    else if (run && cnt != CNT_MAX)  cnt <= cnt + CNT_W'(1);
  end

  assign too_early  = cnt < CNT_W'(EARLY_MIN);
  assign at_close   = cnt == CNT_W'(WIN_CLOSE);
  assign at_release = cnt == CNT_W'(RELEASE_AT);
endmodule

// File: rtl/sqe_burst_meter.sv
// Measures the length of the collision burst in sampled edges.
module sqe_burst_meter #(
  parameter int unsigned MIN_BURST = 10,
  parameter int unsigned MAX_BURST = 30,
  parameter int unsigned LEN_W     = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic inc,
  output logic too_short,
  output logic at_cap
);
  logic [LEN_W-1:0] len;

  always_ff @(posedge clk) begin
    if (!rst_n)      len <= '0;
    else if (start)  len <= LEN_W'(1);
    else if (inc)    len <= len + LEN_W'(1);
  end

  assign too_short = len < LEN_W'(MIN_BURST);
  assign at_cap    = len == LEN_W'(MAX_BURST);
endmodule

// File: rtl/sqe_test_monitor.sv
module sqe_test_monitor
  import sqe_mon_pkg::*;
#(
  parameter int unsigned EARLY_MIN  = 12,
  parameter int unsigned WIN_CLOSE  = 32,
  parameter int unsigned HOLD_EXTRA = 30,
  parameter int unsigned MIN_BURST  = 10,
  parameter int unsigned MAX_BURST  = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tx_active,
  input  logic aui_sel,
  input  logic carrier_in,
  input  logic col_active,
  output logic carrier_out,
  output logic mask_active,
  output logic sqe_err
);
  localparam int unsigned RELEASE_AT = WIN_CLOSE + HOLD_EXTRA;
  localparam int unsigned CNT_W      = $clog2(RELEASE_AT + 2);
  localparam int unsigned LEN_W      = $clog2(MAX_BURST + 2);

  sqe_state_e state, state_nx;
  logic end_pulse, too_early, at_close, at_release, too_short, at_cap;
  logic err_nx, meter_start, meter_inc;

  sqe_tx_edge u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_active (tx_active),
    .aui_sel   (aui_sel),
    .end_pulse (end_pulse)
  );

  sqe_win_timer #(
    .EARLY_MIN  (EARLY_MIN),
    .WIN_CLOSE  (WIN_CLOSE),
    .RELEASE_AT (RELEASE_AT),
    .CNT_W      (CNT_W)
  ) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (end_pulse),
    .run        (state != ST_IDLE),
    .too_early  (too_early),
    .at_close   (at_close),
    .at_release (at_release)
  );

  sqe_burst_meter #(
    .MIN_BURST (MIN_BURST),
    .MAX_BURST (MAX_BURST),
    .LEN_W     (LEN_W)
  ) u_meter (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (meter_start),
    .inc       (meter_inc),
    .too_short (too_short),
    .at_cap    (at_cap)
  );

  assign meter_start = (state == ST_WAIT) && col_active && !too_early && !tx_active;
  assign meter_inc   = (state == ST_BURST) && col_active && !at_cap && !tx_active;

  always_comb begin
    state_nx = state;
    err_nx   = 1'b0;
    if (state != ST_IDLE && tx_active) begin
      state_nx = ST_IDLE;                 // a new frame cancels the check
    end else begin
      unique case (state)
        ST_IDLE: if (end_pulse) state_nx = ST_WAIT;
        ST_WAIT: begin
          if (col_active) begin
            if (too_early) begin
              state_nx = ST_HOLD;
              err_nx   = 1'b1;
            end else begin
              state_nx = ST_BURST;
            end
          end else if (at_close) begin
            state_nx = ST_HOLD;
            err_nx   = 1'b1;
          end
        end
        ST_BURST: begin
          if (!col_active) begin
            state_nx = ST_IDLE;
            err_nx   = too_short;
          end else if (at_cap) begin
            state_nx = ST_IDLE;
          end
        end
        ST_HOLD: if (at_release) state_nx = ST_IDLE;
        default: state_nx = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      sqe_err <= 1'b0;
    end else begin
      state   <= state_nx;
      sqe_err <= err_nx;
    end
  end

  assign mask_active = (state != ST_IDLE);
  assign carrier_out = carrier_in & ~mask_active;
endmodule

// File: rtl/sqe_test_monitor_chk.sv
module sqe_test_monitor_chk #(
  parameter int unsigned MASK_LIMIT = 62
) (
  input logic clk,
  input logic rst_n,
  input logic tx_active,
  input logic aui_sel,
  input logic mask_active,
  input logic sqe_err
);
  logic       prev_tx;
  logic [7:0] run_len;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_tx <= 1'b0;
      run_len <= '0;
    end else begin
      prev_tx <= tx_active;
      run_len <= mask_active ? ((run_len == 8'hFF) ? run_len : run_len + 8'd1) : 8'd0;
    end
  end

  p_end_masks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_tx && !tx_active && aui_sel) |=> mask_active);

  p_mask_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run_len <= 8'(MASK_LIMIT));

  p_abort_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_active && tx_active) |=> (!mask_active && !sqe_err));

  p_tp_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_tx && !tx_active && !aui_sel) |=> !mask_active);

  p_err_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sqe_err |=> !sqe_err);

  p_err_after_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sqe_err |-> $past(mask_active));
endmodule

bind sqe_test_monitor sqe_test_monitor_chk #(
  .MASK_LIMIT (WIN_CLOSE + HOLD_EXTRA)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tx_active   (tx_active),
  .aui_sel     (aui_sel),
  .mask_active (mask_active),
  .sqe_err     (sqe_err)
);

// File: tb/sqe_test_monitor_test.sv
module sqe_test_monitor_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_active = 1'b0, aui_sel = 1'b1, carrier_in = 1'b0, col_active = 1'b0;
  logic carrier_out, mask_active, sqe_err;
  int   n_tests = 0, n_fail = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  sqe_test_monitor uut (
    .clk(clk), .rst_n(rst_n), .tx_active(tx_active), .aui_sel(aui_sel),
    .carrier_in(carrier_in), .col_active(col_active),
    .carrier_out(carrier_out), .mask_active(mask_active), .sqe_err(sqe_err)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Expected edge after which masking drops (0 = never masks) and error edge (-1 = none).
  function automatic int exp_end(input bit aui, input int s, input int len, input int ab);
    int e;
    if (!aui) return 0;
    if (s == 0 || s > 32 || s < 12) e = 62;
    else if (len > 30)              e = s + 30;
    else                            e = s + len;
    if (ab > 0 && ab <= e) e = ab;
    return e;
  endfunction

  function automatic int exp_err(input bit aui, input int s, input int len, input int ab);
    int r;
    if (!aui) return -1;
    if (s == 0 || s > 32)  r = 32;
    else if (s < 12)       r = s;
    else if (len < 10)     r = s + len;
    else                   r = -1;
    if (ab > 0 && r >= ab) r = -1;
    return r;
  endfunction

  function automatic string tag_of(input bit aui, input int s, input int len, input int ab);
    int e;
    e = exp_end(aui, s, len, 0);
    if (!aui)                       return "R9";
    if (ab > 0 && ab <= e)          return "R8";
    if (s == 0 || s > 32)           return "R4";
    if (s < 12)                     return "R5";
    if (len < 10)                   return "R6";
    if (len > 30)                   return "R7";
    return "R3";
  endfunction

  task automatic run_case(input bit aui, input int s, input int len, input int ab);
    int    e, er;
    string tg, rq;
    e  = exp_end(aui, s, len, ab);
    er = exp_err(aui, s, len, ab);
    tg = tag_of(aui, s, len, ab);
    @(negedge clk);
    aui_sel = aui; col_active = 1'b0; tx_active = 1'b1;
    repeat (3) @(negedge clk);
    tx_active = 1'b0;
    @(negedge clk);  // after edge 0
    for (int i = 0; i <= 70; i++) begin
      check((i == 0 && aui) ? "R2" : tg, $sformatf("mask after edge %0d", i),
            int'(mask_active), int'(i < e));
      rq = (er >= 0 && i == er + 1) ? "R10" : tg;
      check(rq, $sformatf("err after edge %0d", i), int'(sqe_err), int'(i == er));
      carrier_in = 1'($urandom_range(0, 1));
      #1;
      check("R2", "carrier_out", int'(carrier_out), int'(carrier_in && !(i < e)));
      col_active = (s > 0 && i + 1 >= s && i + 1 < s + len);
      tx_active  = (ab > 0 && i + 1 >= ab);
      @(negedge clk);
    end
    col_active = 1'b0;
    tx_active  = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17_C0DE));
    repeat (4) @(negedge clk);
    carrier_in = 1'b1;
    #1;
    check("R1", "mask in reset", int'(mask_active), 0);
    check("R1", "err in reset", int'(sqe_err), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "mask after reset", int'(mask_active), 0);
    check("R1", "err after reset", int'(sqe_err), 0);
    check("R1", "carrier pass", int'(carrier_out), 1);

    run_case(1, 20, 14, 0);   // R3 nominal
    run_case(1, 12, 10, 0);   // R3 earliest start, shortest good burst
    run_case(1, 32, 30, 0);   // R3 latest start, longest good burst
    run_case(1, 0, 0, 0);     // R4 no burst
    run_case(1, 33, 12, 0);   // R4 one edge too late
    run_case(1, 11, 12, 0);   // R5 one edge too early
    run_case(1, 1, 5, 0);     // R5 immediate activity
    run_case(1, 20, 9, 0);    // R6 one edge short
    run_case(1, 15, 31, 0);   // R7 just over cap
    run_case(1, 15, 40, 0);   // R7 long burst
    run_case(1, 0, 0, 20);    // R8 abort before error
    run_case(1, 20, 14, 25);  // R8 abort inside burst
    run_case(1, 5, 3, 40);    // R8 abort after early error
    run_case(0, 20, 14, 0);   // R9 twisted-pair
    run_case(0, 0, 0, 0);     // R9 twisted-pair, no burst

    for (int k = 0; k < 40; k++) begin
      bit aui_r;
      int s_r, l_r, a_r;
      aui_r = ($urandom_range(0, 3) != 0);
      s_r   = $urandom_range(0, 40);
      l_r   = $urandom_range(1, 40);
      a_r   = ($urandom_range(0, 4) == 0) ? $urandom_range(1, 65) : 0;
      run_case(aui_r, s_r, l_r, a_r);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule